// File: doc/BRIEF.md
# Receive Byte Queue with Run-Time Depth Switch and Line Status

This block is the receive side of a 16550-compatible serial controller. It keeps received bytes in a queue that holds either one byte or a full `DEPTH`-entry buffer. Which of the two applies depends on the enable bit of the FIFO control register. Every time that bit changes, the queue is emptied and starts over at the new depth. Bytes arrive from an external receive source over a valid/ready handshake. In loopback mode they come instead from CPU writes to the data register.

On the CPU side there is one strobe-based register port. A read of the data register pops the oldest byte. A read of the line status register reports data-ready and overrun, and it always reports the transmitter as idle. A write to the FIFO control register can resize or flush the queue and stores a masked copy of the written value.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset the queue is empty, the stored control value `fcr_o` is 0x00, the effective depth is 1 entry and the overrun flag is clear.
- R2: The effective depth is `DEPTH` entries (16 by default) while control bit 0 (enable) is 1, and 1 entry while it is 0.
- R3: A control write whose bit 0 differs from the stored bit 0 empties the queue, and the queue then uses the depth that the new bit selects. A control write that leaves bit 0 unchanged does not empty the queue unless R5 applies.
- R4: A control write with bit 0 clear stores 0x00. A control write with bit 0 set keeps only bits 7, 6, 3 and 0 of the written value (mask 0xC9).
- R5: A control write with both bit 0 and bit 1 (receive reset) set empties the queue, and the queue keeps the full depth.
- R6: While `lpbk_en_i` is high, a data-register write pushes the byte into the queue. If the queue is full, the byte is dropped and the overrun flag is set.
- R7: A line status read returns bit 0 = data ready (queue not empty), bit 1 = overrun, bit 5 = 1 and bit 6 = 1, with all other bits 0. On an empty queue with no overrun it returns 0x60.
- R8: A line status read returns the overrun flag and clears it, so the next line status read shows bit 1 = 0.
- R9: While `lpbk_en_i` is high, `ext_ready_o` is 1 and external bytes are accepted and discarded.
- R10: While `lpbk_en_i` is low, `ext_ready_o` is 1 exactly when the queue is not full. Accepted external bytes are read back in arrival order.
- R11: A data-register read on an empty queue returns 0xFF and leaves the queue unchanged.
- R12: The read pointer, the write pointer and the count wrap modulo the effective depth. A push and a pop in the same cycle on a non-empty queue leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lpbk_en_i | input | 1 | Loopback mode: data writes feed the queue and external bytes are discarded |
| ext_valid_i | input | 1 | External receive byte valid |
| ext_data_i | input | DW | External receive byte |
| ext_ready_o | output | 1 | External byte accepted this cycle when high together with valid |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_rd_i | input | 1 | Register read strobe (ignored when the write strobe is also high) |
| cpu_sel_i | input | 2 | Register select: 0 data, 1 FIFO control, 2 line status |
| cpu_wdata_i | input | 8 | Register write data |
| cpu_rdata_o | output | 8 | Read data for the selected register, valid in the strobe cycle; 0xFF for unused selects |
| fcr_o | output | 8 | Stored FIFO control value |

## Verification
The bench builds the block with its defaults, `DEPTH` = 16 and `DW` = 8. With these values the bench can fill the deep queue completely in sixteen loopback writes, reach the overrun on the seventeenth write, and move both pointers past the last slot to show the wrap. The one-entry mode makes full-queue back-pressure and dropped loopback bytes visible after a single byte. Flushes are confirmed only through what the ports show: the line status reads 0x60 and no stale byte is read back.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_FCR  = 2'd1,
    SEL_LSR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned FCR_EN_BIT   = 0;
  localparam int unsigned FCR_RRST_BIT = 1;
  localparam logic [7:0]  FCR_KEEP     = 8'hC9;

  localparam int unsigned LSR_DR_BIT   = 0;
  localparam int unsigned LSR_OE_BIT   = 1;
  localparam int unsigned LSR_THRE_BIT = 5;
  localparam int unsigned LSR_TEMT_BIT = 6;
endpackage

// File: rtl/rxq_buffer.sv
module rxq_buffer #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          deep_i,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] count_q, limit;

  assign limit = deep_i ? CW'(DEPTH) : CW'(1);

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input logic [CW-1:0] lim);
    return (CW'(p) == lim - CW'(1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= adv(wr_ptr_q, limit);
      if (pop_i)  rd_ptr_q <= adv(rd_ptr_q, limit);
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  assign head_o   = mem_q[rd_ptr_q];
  assign count_o  = count_q;
  assign rd_ptr_o = rd_ptr_q;
  assign full_o   = (count_q == limit);
  assign empty_o  = (count_q == '0);
endmodule

// File: rtl/rx_fcr_ctrl.sv
module rx_fcr_ctrl
  import serial_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] fcr_o,
  output logic       deep_o,
  output logic       flush_o
);
  logic [7:0] fcr_q;
  logic       mode_flip, rx_rst;

  assign mode_flip = wdata_i[FCR_EN_BIT] ^ fcr_q[FCR_EN_BIT];
  assign rx_rst    = wdata_i[FCR_EN_BIT] & wdata_i[FCR_RRST_BIT];
  assign flush_o   = wr_i & (mode_flip | rx_rst);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fcr_q <= '0;
    else if (wr_i) fcr_q <= wdata_i[FCR_EN_BIT] ? (wdata_i & FCR_KEEP) : 8'h00;
  end

  assign fcr_o  = fcr_q;
  assign deep_o = fcr_q[FCR_EN_BIT];
endmodule

// File: rtl/rx_lsr_unit.sv
module rx_lsr_unit
  import serial_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ovr_set_i,
  input  logic       lsr_rd_i,
  input  logic       data_rdy_i,
  output logic [7:0] lsr_o
);
  logic ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (ovr_set_i) ovr_q <= 1'b1;
    else if (lsr_rd_i)  ovr_q <= 1'b0;
  end

  always_comb begin
    lsr_o               = '0;
    lsr_o[LSR_DR_BIT]   = data_rdy_i;
    lsr_o[LSR_OE_BIT]   = ovr_q;
    lsr_o[LSR_THRE_BIT] = 1'b1;
    lsr_o[LSR_TEMT_BIT] = 1'b1;
  end
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lpbk_en_i,
  input  logic          ext_valid_i,
  input  logic [DW-1:0] ext_data_i,
  output logic          ext_ready_o,
  input  logic          cpu_wr_i,
  input  logic          cpu_rd_i,
  input  logic [1:0]    cpu_sel_i,
  input  logic [7:0]    cpu_wdata_i,
  output logic [7:0]    cpu_rdata_o,
  output logic [7:0]    fcr_o
);
  reg_sel_e      sel;
  logic          rd_en, wr_dat, wr_fcr, rd_dat, rd_lsr;
  logic          deep, flush, push, pop, full, empty, lb_push, ext_push;
  logic [DW-1:0] head, push_data;
  logic [CW-1:0] count;
  logic [PW-1:0] rd_ptr;
  logic [7:0]    lsr;

  assign sel    = reg_sel_e'(cpu_sel_i);
  assign rd_en  = cpu_rd_i & ~cpu_wr_i;
  assign wr_dat = cpu_wr_i & (sel == SEL_DATA);
  assign wr_fcr = cpu_wr_i & (sel == SEL_FCR);
  assign rd_dat = rd_en & (sel == SEL_DATA);
  assign rd_lsr = rd_en & (sel == SEL_LSR);

  // loopback: CPU data writes feed the queue, external side is drained
  assign lb_push     = wr_dat & lpbk_en_i;
  assign ext_ready_o = lpbk_en_i | ~full;
  assign ext_push    = ext_valid_i & ~lpbk_en_i & ~full;
  assign push        = (lb_push & ~full) | ext_push;
  assign push_data   = lpbk_en_i ? DW'(cpu_wdata_i) : ext_data_i;
  assign pop         = rd_dat & ~empty;

  rx_fcr_ctrl u_fcr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_fcr),
    .wdata_i (cpu_wdata_i),
    .fcr_o   (fcr_o),
    .deep_o  (deep),
    .flush_o (flush)
  );

  rxq_buffer #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .deep_i      (deep),
    .flush_i     (flush),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .head_o      (head),
    .count_o     (count),
    .rd_ptr_o    (rd_ptr),
    .full_o      (full),
    .empty_o     (empty)
  );

  rx_lsr_unit u_lsr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ovr_set_i  (lb_push & full),
    .lsr_rd_i   (rd_lsr),
    .data_rdy_i (~empty),
    .lsr_o      (lsr)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: cpu_rdata_o = empty ? 8'hFF : 8'(head);
      SEL_LSR:  cpu_rdata_o = lsr;
      default:  cpu_rdata_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/serial_rx_queue_chk.sv
module serial_rx_queue_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5,
  parameter int unsigned PW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          lpbk_en_i,
  input logic          cpu_wr_i,
  input logic          cpu_rd_i,
  input logic [1:0]    cpu_sel_i,
  input logic [7:0]    cpu_wdata_i,
  input logic [7:0]    cpu_rdata_o,
  input logic          ext_ready_o,
  input logic [7:0]    fcr_o,
  input logic [CW-1:0] count,
  input logic [PW-1:0] rd_ptr,
  input logic          push,
  input logic          pop
);
  logic [CW-1:0] lim;
  assign lim = fcr_o[0] ? CW'(DEPTH) : CW'(1);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= lim); // R2

  AST_FLUSH_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_sel_i == 2'd1 && cpu_wdata_i[0] != fcr_o[0]) |=> (count == '0)); // R3

  AST_RX_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_sel_i == 2'd1 && cpu_wdata_i[1:0] == 2'b11) |=> (count == '0 && fcr_o[0])); // R5

  AST_LSR_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i && !cpu_wr_i && cpu_sel_i == 2'd2) |-> (cpu_rdata_o[6:5] == 2'b11)); // R7

  AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i && !cpu_wr_i && cpu_sel_i == 2'd2) |=> !(cpu_sel_i == 2'd2 && cpu_rdata_o[1])); // R8

  AST_LPBK_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpbk_en_i |-> ext_ready_o); // R9

  AST_READY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lpbk_en_i && count == lim) |-> !ext_ready_o); // R10

  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i && !cpu_wr_i && cpu_sel_i == 2'd0 && count == '0) |=> $stable(rd_ptr)); // R11

  AST_SIM_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && pop && !cpu_wr_i) |=> $stable(count)); // R12
endmodule

bind serial_rx_queue serial_rx_queue_chk #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lpbk_en_i   (lpbk_en_i),
  .cpu_wr_i    (cpu_wr_i),
  .cpu_rd_i    (cpu_rd_i),
  .cpu_sel_i   (cpu_sel_i),
  .cpu_wdata_i (cpu_wdata_i),
  .cpu_rdata_o (cpu_rdata_o),
  .ext_ready_o (ext_ready_o),
  .fcr_o       (fcr_o),
  .count       (count),
  .rd_ptr      (rd_ptr),
  .push        (push),
  .pop         (pop)
);

// File: tb/tb_serial_rx_queue.sv
module tb_serial_rx_queue;
  localparam int unsigned DEPTH = 16;
  localparam logic [1:0] S_DAT = 2'd0, S_FCR = 2'd1, S_LSR = 2'd2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       lpbk = 1'b0, ext_valid = 1'b0, ext_ready;
  logic [7:0] ext_data = '0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0] cpu_sel = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata, fcr;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  serial_rx_queue #(.DEPTH(DEPTH), .DW(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lpbk_en_i(lpbk),
    .ext_valid_i(ext_valid), .ext_data_i(ext_data), .ext_ready_o(ext_ready),
    .cpu_wr_i(cpu_wr), .cpu_rd_i(cpu_rd), .cpu_sel_i(cpu_sel),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .fcr_o(fcr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_sel = s; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); cpu_rd = 1'b1; cpu_sel = s;
    #1 v = cpu_rdata;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic ext(input logic [7:0] d, output logic r);
    @(negedge clk); ext_valid = 1'b1; ext_data = d;
    #1 r = ext_ready;
    @(negedge clk); ext_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 fcr", fcr, 8'h00);
    chk("R1 ready", {7'd0, ext_ready}, 8'h01);
    rd(S_LSR, v); chk("R1 R7 lsr idle", v, 8'h60);
  endtask

  task automatic t_shallow;
    logic [7:0] v; logic r;
    lpbk = 1'b0;
    ext(8'h11, r); chk("R10 ready empty", {7'd0, r}, 8'h01);
    ext(8'h22, r); chk("R2 R10 ready full at depth 1", {7'd0, r}, 8'h00);
    rd(S_LSR, v); chk("R7 data ready", v, 8'h61);
    rd(S_DAT, v); chk("R10 byte", v, 8'h11);
    rd(S_DAT, v); chk("R11 empty read", v, 8'hFF);
    ext(8'h33, r);
    rd(S_DAT, v); chk("R11 pointers kept", v, 8'h33);
    rd(S_LSR, v); chk("R7 empty", v, 8'h60);
  endtask

  task automatic t_loop_shallow;
    logic [7:0] v;
    lpbk = 1'b1;
    wr(S_DAT, 8'hA5);
    wr(S_DAT, 8'h5A);
    rd(S_LSR, v); chk("R6 overrun", v, 8'h63);
    rd(S_LSR, v); chk("R8 overrun cleared", v, 8'h61);
    rd(S_DAT, v); chk("R6 kept byte", v, 8'hA5);
    rd(S_DAT, v); chk("R6 dropped byte", v, 8'hFF);
  endtask

  task automatic t_deep;
    logic [7:0] v;
    lpbk = 1'b1;
    wr(S_FCR, 8'hFF); chk("R4 mask", fcr, 8'hC9);
    for (int i = 0; i < DEPTH; i++) wr(S_DAT, 8'(i * 3 + 1));
    rd(S_LSR, v); chk("R2 full depth no overrun", v, 8'h61);
    wr(S_DAT, 8'hEE);
    rd(S_LSR, v); chk("R6 deep overrun", v, 8'h63);
    for (int i = 0; i < DEPTH; i++) begin
      rd(S_DAT, v); chk("R2 order", v, 8'(i * 3 + 1));
    end
    rd(S_DAT, v); chk("R11 deep empty", v, 8'hFF);
    for (int i = 0; i < 5; i++) wr(S_DAT, 8'(8'h80 + i));
    for (int i = 0; i < 5; i++) begin
      rd(S_DAT, v); chk("R12 wrap", v, 8'(8'h80 + i));
    end
  endtask

  task automatic t_rx_reset;
    logic [7:0] v;
    lpbk = 1'b1;
    for (int i = 0; i < 3; i++) wr(S_DAT, 8'(i));
    wr(S_FCR, 8'h03); chk("R4 R5 fcr", fcr, 8'h01);
    rd(S_LSR, v); chk("R5 flushed", v, 8'h60);
    wr(S_DAT, 8'h44); wr(S_DAT, 8'h55);
    rd(S_LSR, v); chk("R5 still deep", v, 8'h61);
    rd(S_DAT, v); chk("R5 byte0", v, 8'h44);
    rd(S_DAT, v); chk("R5 byte1", v, 8'h55);
  endtask

  task automatic t_mode_change;
    logic [7:0] v;
    lpbk = 1'b1;
    wr(S_DAT, 8'h66);
    wr(S_FCR, 8'hC1); chk("R4 keep", fcr, 8'hC1);
    rd(S_LSR, v); chk("R3 no flush same mode", v, 8'h61);
    wr(S_DAT, 8'h77);
    wr(S_FCR, 8'hF6); chk("R4 clear", fcr, 8'h00);
    rd(S_LSR, v); chk("R3 flush to shallow", v, 8'h60);
    wr(S_DAT, 8'h12); wr(S_DAT, 8'h34);
    rd(S_LSR, v); chk("R3 depth 1 adopted", v, 8'h63);
    wr(S_FCR, 8'h01);
    rd(S_LSR, v); chk("R3 flush to deep", v, 8'h60);
  endtask

  task automatic t_loop_ext;
    logic [7:0] v; logic r;
    lpbk = 1'b1;
    ext(8'h99, r); chk("R9 ready", {7'd0, r}, 8'h01);
    rd(S_LSR, v); chk("R9 discarded", v, 8'h60);
    wr(S_DAT, 8'h01);
    ext(8'h98, r); chk("R9 ready nonempty", {7'd0, r}, 8'h01);
    rd(S_DAT, v); chk("R9 queue untouched", v, 8'h01);
  endtask

  task automatic t_simul;
    logic [7:0] v; logic r;
    lpbk = 1'b0;
    ext(8'h11, r); ext(8'h22, r);
    @(negedge clk);
    ext_valid = 1'b1; ext_data = 8'h33; cpu_rd = 1'b1; cpu_sel = S_DAT;
    #1 v = cpu_rdata; chk("R12 pop during push", v, 8'h11);
    @(negedge clk); ext_valid = 1'b0; cpu_rd = 1'b0;
    rd(S_DAT, v); chk("R12 second", v, 8'h22);
    rd(S_DAT, v); chk("R12 third", v, 8'h33);
    rd(S_DAT, v); chk("R12 count kept", v, 8'hFF);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shallow();
    t_loop_shallow();
    t_deep();
    t_rx_reset();
    t_mode_change();
    t_loop_ext();
    t_simul();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule